// File: doc/BRIEF.md
# Masked Packed Half-Precision Minimum Unit

The unit takes two vectors of packed 16-bit half-precision values and produces, for each lane, the smaller of the two elements. Its comparison is deliberately asymmetric. Whenever the pair cannot be ordered, or whenever both values are zeros of any sign, the second operand's bit pattern is returned unchanged. A signaling NaN in the second operand therefore passes through without being quieted.

A per-lane mask selects which lanes receive a new result. A mask-bypass input makes every lane active. An inactive lane is either cleared or keeps the prior destination value, depending on a mode select. A broadcast input replaces every lane's second operand with element 0 of the second source. The result vector is registered once per input strobe. Bits above the active vector width, up to the maximum destination width, always read zero.

The unit also keeps two sticky status flags, one for invalid inputs and one for denormal inputs. Both hold until reset, and a suppress input stops an operation from setting them.

Top module: `fp16_vmin_unit`

## Requirements
- R1: Each lane holds one 16-bit value, and there are VEC_W/16 lanes. Within a lane the field layout is sign at bit 15, exponent at bits 14:10 and mantissa at bits 9:0. When neither element is NaN and they are not both zero, the result is the first element if it is strictly less than the second; otherwise it is the second element. Ordering follows sign and magnitude, so a larger magnitude is smaller when negative. Subnormals are compared exactly.
- R2: When both elements are zero (+0 is 0x0000, -0 is 0x8000), the result is the second element's exact bits.
- R3: When either element is a NaN (exponent 31 with a nonzero mantissa), the result is the second element's exact bits. A signaling NaN (mantissa bit 9 clear) is not quieted.
- R4: With bcast_i high, every lane uses bits 15:0 of src_b_i as its second element.
- R5: A lane is active when its mask_i bit is set or when no_mask_i is high. Lane g is controlled by mask_i[g].
- R6: An inactive lane gets 0x0000 when zero_mode_i is high and the matching old_dst_i lane when it is low.
- R7: res_o bits from VEC_W up to MAX_W-1 are always zero.
- R8: Results and valid_o appear one cycle after valid_i is sampled high. Without valid_i, res_o holds its value and valid_o is low.
- R9: invalid_o becomes 1 after an unsuppressed operation in which an active lane has a NaN in either element. It stays 1 until reset.
- R10: denorm_o becomes 1 after an unsuppressed operation in which an active lane has a subnormal (exponent 0, mantissa nonzero) in either element. It stays 1 until reset.
- R11: An operation with flag_sup_i high changes neither flag. Inactive lanes never set a flag.
- R12: While rst_ni is low, res_o, valid_o, invalid_o and denorm_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| src_a_i | input | VEC_W | First source vector |
| src_b_i | input | VEC_W | Second source vector |
| mask_i | input | VEC_W/16 | Per-lane write enable |
| no_mask_i | input | 1 | Treat every lane as active |
| zero_mode_i | input | 1 | 1: clear inactive lanes, 0: merge old value |
| bcast_i | input | 1 | Use element 0 of src_b_i in every lane |
| flag_sup_i | input | 1 | Block flag updates for this operation |
| old_dst_i | input | VEC_W | Prior destination value for merging |
| valid_o | output | 1 | Result valid |
| res_o | output | MAX_W | Result vector, upper part zero |
| invalid_o | output | 1 | Sticky NaN-input flag |
| denorm_o | output | 1 | Sticky subnormal-input flag |

## Verification
Directed operations target the pairs where an operand order mix-up would be visible:
- Zero pairs +0/-0 in both orders. A symmetric minimum would return -0 both times.
- Quiet and signaling NaN in the first and in the second position. A design that quiets signaling NaNs would set mantissa bit 9; one that returns the NaN operand would break the first-position case.
- Mixed-sign and negative subnormal pairs. These expose a design that compares raw bit patterns.

Mask, broadcast and mode patterns check that lane g follows mask_i[g] and takes src_b_i element 0 under broadcast. The flag scenarios check three things: suppressed and masked-off NaNs leave both flags clear; the flags stay set once raised; the upper destination bits never leak data.

// File: rtl/fp16min_pkg.sv
package fp16min_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned EXP_W  = 5;
  localparam int unsigned MAN_W  = 10;

  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    logic is_nan;
    logic is_zero;
    logic is_sub;
  } hclass_t;
endpackage

// File: rtl/fp16_class.sv
module fp16_class
  import fp16min_pkg::*;
(
  input  half_t   val_i,
  output hclass_t cls_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f = val_i[HALF_W-2 -: EXP_W];
  assign man_f = val_i[MAN_W-1:0];

  always_comb begin
    cls_o.is_nan  = (&exp_f) && (|man_f);
    cls_o.is_zero = ~|val_i[HALF_W-2:0];
    cls_o.is_sub  = (~|exp_f) && (|man_f);
  end
endmodule

// File: rtl/fp16_lane_min.sv
module fp16_lane_min
  import fp16min_pkg::*;
(
  input  half_t a_i,
  input  half_t b_i,
  output half_t min_o,
  output logic  nan_o,
  output logic  sub_o
);
  hclass_t ca, cb;
  logic    a_lt_b;
  logic    take_b;
  logic    sa, sb;
  logic [HALF_W-2:0] ma, mb;

  fp16_class u_ca (.val_i(a_i), .cls_o(ca));
  fp16_class u_cb (.val_i(b_i), .cls_o(cb));

  assign sa = a_i[HALF_W-1];
  assign sb = b_i[HALF_W-1];
  assign ma = a_i[HALF_W-2:0];
  assign mb = b_i[HALF_W-2:0];

  // sign-magnitude order; both-zero handled separately
  always_comb begin
    if (sa != sb) a_lt_b = sa;
    else if (sa)  a_lt_b = (ma > mb);
    else          a_lt_b = (ma < mb);
  end

  assign take_b = (ca.is_zero && cb.is_zero) || ca.is_nan || cb.is_nan || !a_lt_b;
  assign min_o  = take_b ? b_i : a_i;
  assign nan_o  = ca.is_nan | cb.is_nan;
  assign sub_o  = ca.is_sub | cb.is_sub;
endmodule

// File: rtl/fp16_lane_sel.sv
module fp16_lane_sel
  import fp16min_pkg::*;
(
  input  logic  active_i,
  input  logic  zero_mode_i,
  input  half_t min_i,
  input  half_t old_i,
  input  logic  nan_i,
  input  logic  sub_i,
  output half_t out_o,
  output logic  nan_o,
  output logic  sub_o
);
  always_comb begin
    if (active_i)         out_o = min_i;
    else if (zero_mode_i) out_o = '0;
    else                  out_o = old_i;
  end

  assign nan_o = active_i & nan_i;
  assign sub_o = active_i & sub_i;
endmodule

// File: rtl/fp16_vmin_unit.sv
module fp16_vmin_unit
  import fp16min_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned MAX_W = 512,
  localparam int unsigned LANES = VEC_W / HALF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             no_mask_i,
  input  logic             zero_mode_i,
  input  logic             bcast_i,
  input  logic             flag_sup_i,
  input  logic [VEC_W-1:0] old_dst_i,
  output logic             valid_o,
  output logic [MAX_W-1:0] res_o,
  output logic             invalid_o,
  output logic             denorm_o
);
  logic [VEC_W-1:0] lane_res;
  logic [LANES-1:0] lane_nan, lane_sub;
  logic [VEC_W-1:0] res_q;
  logic             valid_q, inv_q, den_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    half_t b_el, min_v;
    logic  nan_v, sub_v;

    assign b_el = bcast_i ? src_b_i[HALF_W-1:0] : src_b_i[g*HALF_W +: HALF_W];

    fp16_lane_min u_min (
      .a_i   (src_a_i[g*HALF_W +: HALF_W]),
      .b_i   (b_el),
      .min_o (min_v),
      .nan_o (nan_v),
      .sub_o (sub_v)
    );

    fp16_lane_sel u_sel (
      .active_i    (mask_i[g] | no_mask_i),
      .zero_mode_i (zero_mode_i),
      .min_i       (min_v),
      .old_i       (old_dst_i[g*HALF_W +: HALF_W]),
      .nan_i       (nan_v),
      .sub_i       (sub_v),
      .out_o       (lane_res[g*HALF_W +: HALF_W]),
      .nan_o       (lane_nan[g]),
      .sub_o       (lane_sub[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      inv_q   <= 1'b0;
      den_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q <= lane_res;
        if (!flag_sup_i) begin
          inv_q <= inv_q | (|lane_nan);
          den_q <= den_q | (|lane_sub);
        end
      end
    end
  end

  if (MAX_W > VEC_W) begin : g_pad
    assign res_o = {{(MAX_W-VEC_W){1'b0}}, res_q};
  end else begin : g_nopad
    assign res_o = res_q;
  end

  assign valid_o   = valid_q;
  assign invalid_o = inv_q;
  assign denorm_o  = den_q;
endmodule

// File: rtl/fp16_vmin_chk.sv
module fp16_vmin_chk #(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned MAX_W = 512,
  localparam int unsigned LANES = VEC_W / 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [LANES-1:0] mask_i,
  input logic             no_mask_i,
  input logic             zero_mode_i,
  input logic             flag_sup_i,
  input logic             valid_o,
  input logic [MAX_W-1:0] res_o,
  input logic             invalid_o,
  input logic             denorm_o
);
  a_r8_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_valid_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r8_res_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  a_r6_zero_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !no_mask_i && zero_mode_i && mask_i == '0) |=> res_o == '0);
  a_r9_inv_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(invalid_o));
  a_r10_den_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(denorm_o));
  a_r11_sup_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && flag_sup_i) |=> ($stable(invalid_o) && $stable(denorm_o)));

  if (MAX_W > VEC_W) begin : g_up
    a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_o[MAX_W-1:VEC_W] == '0);
  end
endmodule

bind fp16_vmin_unit fp16_vmin_chk #(.VEC_W(VEC_W), .MAX_W(MAX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .mask_i      (mask_i),
  .no_mask_i   (no_mask_i),
  .zero_mode_i (zero_mode_i),
  .flag_sup_i  (flag_sup_i),
  .valid_o     (valid_o),
  .res_o       (res_o),
  .invalid_o   (invalid_o),
  .denorm_o    (denorm_o)
);

// File: tb/sim_fp16_vmin_unit.sv
module sim_fp16_vmin_unit;
  localparam int VW = 256;
  localparam int MW = 512;
  localparam int NL = VW / 16;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          valid_i = 0;
  logic [VW-1:0] src_a_i = '0, src_b_i = '0, old_dst_i = '0;
  logic [NL-1:0] mask_i = '0;
  logic          no_mask_i = 0, zero_mode_i = 0, bcast_i = 0, flag_sup_i = 0;
  logic          valid_o, invalid_o, denorm_o;
  logic [MW-1:0] res_o;

  int total = 0, bad = 0;
  logic exp_inv = 0, exp_den = 0;

  always #2 clk_i = ~clk_i;

  fp16_vmin_unit #(.VEC_W(VW), .MAX_W(MW)) u0 (.*);

  function automatic logic f_nan(logic [15:0] v);
    return (v[14:10] == 5'h1f) && (v[9:0] != 0);
  endfunction
  function automatic logic f_sub(logic [15:0] v);
    return (v[14:10] == 0) && (v[9:0] != 0);
  endfunction
  function automatic logic f_zero(logic [15:0] v);
    return v[14:0] == 0;
  endfunction
  // value of a finite half as real, for ordering
  function automatic real f_val(logic [15:0] v);
    real m;
    int  e;
    e = int'(v[14:10]);
    if (e == 0) m = real'(v[9:0]) / 1024.0 * (2.0 ** -14);
    else if (e == 31) m = 1.0e10;
    else m = (1.0 + real'(v[9:0]) / 1024.0) * (2.0 ** (e - 15));
    return v[15] ? -m : m;
  endfunction
  function automatic logic [15:0] f_min(logic [15:0] a, logic [15:0] b);
    if (f_zero(a) && f_zero(b)) return b;
    if (f_nan(a) || f_nan(b)) return b;
    if (f_val(a) < f_val(b)) return a;
    return b;
  endfunction

  function automatic logic [15:0] rnd_half();
    logic [15:0] r;
    r = 16'($urandom);
    case ($urandom % 9)
      0: r = {r[15], 15'h0};
      1: r = {r[15], 5'h0, (r[9:0] == 0) ? 10'h1 : r[9:0]};
      2: r = {r[15], 5'h1f, 1'b1, r[8:0]};
      3: r = {r[15], 5'h1f, 1'b0, (r[8:0] == 0) ? 9'h1 : r[8:0]};
      4: r = {r[15], 5'h1f, 10'h0};
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] rep(logic [15:0] v, int l);
    return v;
  endfunction

  task automatic check(string tag, logic [MW-1:0] act, logic [MW-1:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic run_op(string tag);
    logic [MW-1:0] exp_r;
    logic          any_n, any_s;
    exp_r = '0;
    any_n = 0;
    any_s = 0;
    for (int l = 0; l < NL; l++) begin
      logic [15:0] a, b;
      logic        act;
      a = src_a_i[l*16 +: 16];
      b = bcast_i ? src_b_i[15:0] : src_b_i[l*16 +: 16];
      act = mask_i[l] | no_mask_i;
      if (act) begin
        exp_r[l*16 +: 16] = f_min(a, b);
        any_n |= f_nan(a) | f_nan(b);
        any_s |= f_sub(a) | f_sub(b);
      end else if (!zero_mode_i) exp_r[l*16 +: 16] = old_dst_i[l*16 +: 16];
    end
    if (!flag_sup_i) begin
      exp_inv |= any_n;
      exp_den |= any_s;
    end
    valid_i = 1;
    @(negedge clk_i);
    valid_i = 0;
    check(tag, res_o, exp_r);
    check("R8 valid", MW'(valid_o), MW'(1));
    check("R9 inv", MW'(invalid_o), MW'(exp_inv));
    check("R10 den", MW'(denorm_o), MW'(exp_den));
    check("R7 upper", MW'(res_o[MW-1:VW]), '0);
  endtask

  task automatic fill(logic [15:0] a, logic [15:0] b);
    for (int l = 0; l < NL; l++) begin
      src_a_i[l*16 +: 16] = a;
      src_b_i[l*16 +: 16] = b;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [MW-1:0] hold;
    void'($urandom(32'd7321));
    #1;
    check("R12 res", res_o, '0);
    check("R12 flags", MW'({valid_o, invalid_o, denorm_o}), '0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    no_mask_i = 1;

    // R1 ordinary values, mixed signs
    fill(16'h3c00, 16'h4000); run_op("R1 pos");
    fill(16'hc000, 16'hbc00); run_op("R1 neg");
    fill(16'h3c00, 16'hbc00); run_op("R1 mix");
    // R8 hold
    hold = res_o;
    @(negedge clk_i);
    check("R8 hold", res_o, hold);
    check("R8 vlow", MW'(valid_o), '0);
    // R2 zeros
    fill(16'h0000, 16'h8000); run_op("R2 pz_nz");
    fill(16'h8000, 16'h0000); run_op("R2 nz_pz");
    // R11: suppressed NaN/sub, then masked-off NaN
    flag_sup_i = 1;
    fill(16'h7e00, 16'h0001); run_op("R11 sup");
    flag_sup_i = 0;
    no_mask_i = 0; zero_mode_i = 0; mask_i = 16'h00ff;
    fill(16'h3c00, 16'h3800);
    src_a_i[255:240] = 16'h7c01; src_b_i[239:224] = 16'h0002;
    old_dst_i = {NL{16'h1234}};
    run_op("R11 masked");
    // R10 subnormal exact compare (negative)
    no_mask_i = 1;
    fill(16'h8003, 16'h8002); run_op("R10 sub");
    // R3 NaN
    fill(16'h7e00, 16'h3c00); run_op("R3 qnan_a");
    fill(16'h3c00, 16'h7c01); run_op("R3 snan_b");
    fill(16'hfd55, 16'h7e01); run_op("R3 both");
    // R4 broadcast
    bcast_i = 1;
    for (int l = 0; l < NL; l++) src_a_i[l*16 +: 16] = 16'(16'h3c00 + l);
    src_b_i = '1; src_b_i[15:0] = 16'h3c04;
    run_op("R4 bcast");
    bcast_i = 0;
    // R5, R6
    no_mask_i = 0; mask_i = 16'ha5c3; zero_mode_i = 1;
    fill(16'h4000, 16'h4400); run_op("R5 mask zero");
    zero_mode_i = 0; old_dst_i = {NL{16'hbeef}};
    run_op("R6 merge");
    mask_i = '0; zero_mode_i = 1; run_op("R6 allzero");

    for (int i = 0; i < 400; i++) begin
      for (int l = 0; l < NL; l++) begin
        src_a_i[l*16 +: 16] = rnd_half();
        src_b_i[l*16 +: 16] = ($urandom % 6 == 0) ? src_a_i[l*16 +: 16] : rnd_half();
        old_dst_i[l*16 +: 16] = 16'($urandom);
      end
      mask_i = NL'($urandom);
      no_mask_i = ($urandom % 4) == 0;
      zero_mode_i = 1'($urandom);
      bcast_i = ($urandom % 5) == 0;
      flag_sup_i = ($urandom % 4) == 0;
      run_op("R1 rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule